// File: doc/BRIEF.md
# RTC Interrupt and Alarm Controller

This block produces the active-low interrupt line and the square-wave output of a real-time clock. It receives three kinds of event. The first is a periodic tick that arrives already at the selected rate. The second is a one-cycle pulse at the end of each time update. The third is an alarm match, which the block works out itself by comparing the current hours, minutes and seconds with three alarm bytes.

Each event sets its own status flag, whether or not its enable bit is set. The interrupt line goes low only while a flag and its matching enable are both 1.

Software does four things with the block:
- It writes the four enable bits through a control write port.
- It reads the flag register, which returns all three flags and then clears them.
- It places the clock in set mode through a separate input. Entering set mode drops the update-ended enable.
- It asserts a synchronous active-low reset, which clears every enable bit.

The rate divider sits outside the block. The square wave therefore toggles on each periodic tick while its enable is 1, so it runs at half the tick rate.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears all four enable bits and all three flags, and drives `sqw` low. `irq_n` is then high.
- R2: Each `rate_tick` pulse sets the periodic flag (`flags_out[0]`) even when the periodic enable (`en_out[0]`) is 0. With that enable at 0, `irq_n` stays high.
- R3: `irq_n` is low exactly when at least one flag is 1 and its enable is also 1. The pairs are periodic flag bit 0 with enable bit 0, alarm flag bit 1 with enable bit 1, and update-ended flag bit 2 with enable bit 2.
- R4: While `flag_rd` is high, `flags_out` shows the current flags. After that clock edge all three flags are 0, unless a new event arrived in the same cycle. `irq_n` then returns high.
- R5: An `upd_pulse` sets the update-ended flag (`flags_out[2]`). When hours, minutes and seconds all match their alarm bytes, the same pulse also sets the alarm flag (`flags_out[1]`). Both flags are set even with their enables at 0.
- R6: An alarm byte whose bits [7:6] are 2'b11 matches any value of its time field. Any other alarm byte matches only an equal time byte. A single mismatching field prevents the alarm flag from being set.
- R7: The alarm is compared only when `upd_pulse` is high. A time that keeps matching sets no further alarm flag until the next `upd_pulse`.
- R8: A 0-to-1 change of `set_mode` clears the update-ended enable (`en_out[2]`), even if a control write in the same cycle sets it. The other three enables are left unchanged.
- R9: A control write loads `ctrl_wdata[3:0]` into the enables. The bit order is periodic [0], alarm [1], update-ended [2] and square-wave [3].
- R10: With the square-wave enable at 1, `sqw` inverts on the clock edge of each `rate_tick`. In the cycle after that enable reads 0, `sqw` is low.
- R11: An event that arrives in the same cycle as a flag read leaves its flag set after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Enable bits to write: {sqw, upd, alm, per} |
| set_mode | input | 1 | Clock set mode; its rising edge clears the update-ended enable |
| rate_tick | input | 1 | One-cycle periodic tick at the selected rate |
| upd_pulse | input | 1 | One-cycle pulse at the end of a time update |
| flag_rd | input | 1 | Flag register read; clears the flags after this cycle |
| cur_hr | input | 8 | Current hours byte |
| cur_min | input | 8 | Current minutes byte |
| cur_sec | input | 8 | Current seconds byte |
| alm_hr | input | 8 | Alarm hours byte (11xxxxxx is a wildcard) |
| alm_min | input | 8 | Alarm minutes byte (11xxxxxx is a wildcard) |
| alm_sec | input | 8 | Alarm seconds byte (11xxxxxx is a wildcard) |
| irq_n | output | 1 | Interrupt request, active low |
| sqw | output | 1 | Square-wave output |
| en_out | output | 4 | Current enables: {sqw, upd, alm, per} |
| flags_out | output | 3 | Current flags: {upd, alm, per} |

## Verification
The assertions check the rules that hold cycle by cycle on every cycle:
- Each event sets its flag one edge later.
- A read empties the flags when no event collides with it.
- `irq_n` agrees with the enabled flags.
- The rise of `set_mode` drops the update-ended enable.
- `sqw` inverts on ticks and falls once its enable is 0.
- The alarm flag follows an independent field comparison made on each update pulse.

Some outcomes only the bench's scenarios can show:
- Which enable bits survive a reset or a set-mode entry.
- That the wildcard code matches while an ordinary mismatch blocks the alarm.
- That a time held at a match raises no second alarm.
- That the flags read back match the events that were driven.

// File: rtl/rtc_irq_pkg.sv
// Package: shared widths and record types for the RTC interrupt controller.
// Assumes: the time fields are one byte each; the wildcard code sits in the two top bits.
package rtc_irq_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned N_FIELDS = 3;   // hours, minutes, seconds
    localparam int unsigned N_SRC    = 3;   // periodic, alarm, update-ended
    localparam int unsigned EN_W     = N_SRC + 1;
    localparam logic [1:0]  WILDCARD = 2'b11;

    // Enable bits, packed in the order of the control write bits.
    typedef struct packed {
        logic sqw;
        logic upd;
        logic alm;
        logic per;
    } rtc_en_t;

    // Status flags, packed in the order of the flag read bits.
    typedef struct packed {
        logic upd;
        logic alm;
        logic per;
    } rtc_flags_t;

endpackage

// File: rtl/rtc_alarm_match.sv
// Module: compares each time field with its alarm byte and reports a full match.
// Assumes: an alarm byte whose two top bits equal WILDCARD matches any value of its field.
module rtc_alarm_match #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned N_FIELDS = 3,
    parameter logic [1:0]  WILDCARD = 2'b11
) (
    input  logic [N_FIELDS-1:0][BYTE_W-1:0] cur_time,
    input  logic [N_FIELDS-1:0][BYTE_W-1:0] alm_time,
    output logic                            all_match
);

    localparam int unsigned TOP = BYTE_W - 1;

    logic [N_FIELDS-1:0] field_ok;

    // One comparator per field, built by a generate loop.
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        logic is_wild;
        logic is_equal;
        // Decide whether this field accepts the current time value.
        always_comb begin
            is_wild     = (alm_time[g][TOP -: 2] == WILDCARD);
            is_equal    = (alm_time[g] == cur_time[g]);
            field_ok[g] = is_wild | is_equal;
        end
    end

    // The alarm matches only when every field agrees.
    always_comb all_match = &field_ok;

endmodule

// File: rtl/rtc_irq_enables.sv
// Module: holds the four enable bits; a control write loads them, reset clears them,
// and entering set mode drops the update-ended enable.
// Assumes: synchronous active-low reset; a set-mode rise wins over a same-cycle write.
module rtc_irq_enables
    import rtc_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ctrl_we,
    input  rtc_en_t ctrl_wdata,
    input  logic    set_mode,
    output rtc_en_t en_q
);

    logic    set_prev_q;
    logic    set_rise;
    rtc_en_t en_d;

    // Track set_mode so that its rising edge can be seen (reset does not hide a level).
    always_ff @(posedge clk) begin
        set_prev_q <= set_mode;
    end

    // Find the set-mode rise and work out the next enable value.
    always_comb begin
        set_rise = set_mode & ~set_prev_q;
        en_d     = en_q;
        if (ctrl_we) begin
            en_d = ctrl_wdata;
        end
        if (set_rise) begin
            en_d.upd = 1'b0;
        end
    end

    // Enable register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

endmodule

// File: rtl/rtc_irq_flags.sv
// Module: keeps the three status flags and drives the active-low interrupt.
// Assumes: events are one-cycle pulses; a read clears the flags unless an event
// arrives in the same cycle, in which case that event's flag stays set.
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rtc_flags_t evt,
    input  logic       flag_rd,
    input  rtc_en_t    en,
    output rtc_flags_t flags_q,
    output logic       irq_n
);

    rtc_flags_t flags_d;
    rtc_flags_t enabled;

    // Next flag value: a read clears, and events set on top of that.
    always_comb begin
        flags_d = flag_rd ? '0 : flags_q;
        flags_d = flags_d | evt;
    end

    // Flag register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // Combine the enabled flags into the active-low request.
    always_comb begin
        enabled.per = flags_q.per & en.per;
        enabled.alm = flags_q.alm & en.alm;
        enabled.upd = flags_q.upd & en.upd;
        irq_n       = ~(|enabled);
    end

endmodule

// File: rtl/rtc_sqw_gen.sv
// Module: square-wave output that inverts on each periodic tick while enabled.
// Assumes: the tick already arrives at the selected rate; when disabled the output is held low.
module rtc_sqw_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic sqw_en,
    input  logic rate_tick,
    output logic sqw_q
);

    // Toggle on a tick while enabled; otherwise park the output low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sqw_q <= 1'b0;
        end else if (!sqw_en) begin
            sqw_q <= 1'b0;
        end else if (rate_tick) begin
            sqw_q <= ~sqw_q;
        end
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
// Module: top of the RTC interrupt controller. It wires together the enables, the alarm
// comparator, the flags with the interrupt, and the square-wave generator.
// Assumes: the alarm is compared only on update pulses; all inputs are synchronous to clk.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [EN_W-1:0]   ctrl_wdata,
    input  logic              set_mode,
    input  logic              rate_tick,
    input  logic              upd_pulse,
    input  logic              flag_rd,
    input  logic [BYTE_W-1:0] cur_hr,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] alm_hr,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_sec,
    output logic              irq_n,
    output logic              sqw,
    output logic [EN_W-1:0]   en_out,
    output logic [N_SRC-1:0]  flags_out
);

    logic [N_FIELDS-1:0][BYTE_W-1:0] cur_time;
    logic [N_FIELDS-1:0][BYTE_W-1:0] alm_time;
    logic       alarm_hit;
    rtc_en_t    en_q;
    rtc_flags_t flags_q;
    rtc_flags_t evt;

    // Gather the separate time bytes into field arrays.
    always_comb begin
        cur_time = {cur_hr, cur_min, cur_sec};
        alm_time = {alm_hr, alm_min, alm_sec};
    end

    rtc_alarm_match #(
        .BYTE_W   (BYTE_W),
        .N_FIELDS (N_FIELDS),
        .WILDCARD (WILDCARD)
    ) u_match (
        .cur_time  (cur_time),
        .alm_time  (alm_time),
        .all_match (alarm_hit)
    );

    rtc_irq_enables u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (rtc_en_t'(ctrl_wdata)),
        .set_mode   (set_mode),
        .en_q       (en_q)
    );

    // Build the event vector; the alarm is tested only on an update pulse.
    always_comb begin
        evt.per = rate_tick;
        evt.alm = upd_pulse & alarm_hit;
        evt.upd = upd_pulse;
    end

    rtc_irq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .flag_rd (flag_rd),
        .en      (en_q),
        .flags_q (flags_q),
        .irq_n   (irq_n)
    );

    rtc_sqw_gen u_sqw (
        .clk       (clk),
        .rst_n     (rst_n),
        .sqw_en    (en_q.sqw),
        .rate_tick (rate_tick),
        .sqw_q     (sqw)
    );

    // Bring the enable and flag state out to the ports.
    always_comb begin
        en_out    = en_q;
        flags_out = flags_q;
    end

endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
// Checker: temporal rules of the RTC interrupt controller, observed at its ports.
// Assumes: it is bound to every instance of rtc_irq_ctrl.
module rtc_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_mode,
    input logic       rate_tick,
    input logic       upd_pulse,
    input logic       flag_rd,
    input logic [7:0] cur_hr,
    input logic [7:0] cur_min,
    input logic [7:0] cur_sec,
    input logic [7:0] alm_hr,
    input logic [7:0] alm_min,
    input logic [7:0] alm_sec,
    input logic       irq_n,
    input logic       sqw,
    input logic [3:0] en_out,
    input logic [2:0] flags_out
);

    // Field match, rebuilt on its own here.
    function automatic logic fld_ok(input logic [7:0] a, input logic [7:0] c);
        return (a[7] & a[6]) | (a == c);
    endfunction

    logic hit;
    // Reference alarm match built from the ports.
    always_comb hit = fld_ok(alm_hr, cur_hr) & fld_ok(alm_min, cur_min) & fld_ok(alm_sec, cur_sec);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (en_out == 4'b0 && flags_out == 3'b0 && !sqw));

    // R2
    per_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_tick |=> flags_out[0]);

    // R3
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((flags_out & en_out[2:0]) != 3'b0));

    // R3
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_out & en_out[2:0]) != 3'b0) |-> !irq_n);

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !rate_tick && !upd_pulse) |=> (flags_out == 3'b0));

    // R5
    upd_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> flags_out[2]);

    // R6
    alarm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && hit) |=> flags_out[1]);

    // R7
    alarm_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !upd_pulse) |=> !flags_out[1]);

    // R8
    set_drops_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(set_mode) |=> !en_out[2]);

    // R10
    sqw_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_out[3] |=> !sqw);

    // R10
    sqw_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_out[3] && rate_tick) |=> (sqw != $past(sqw)));

endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_mode  (set_mode),
    .rate_tick (rate_tick),
    .upd_pulse (upd_pulse),
    .flag_rd   (flag_rd),
    .cur_hr    (cur_hr),
    .cur_min   (cur_min),
    .cur_sec   (cur_sec),
    .alm_hr    (alm_hr),
    .alm_min   (alm_min),
    .alm_sec   (alm_sec),
    .irq_n     (irq_n),
    .sqw       (sqw),
    .en_out    (en_out),
    .flags_out (flags_out)
);

// File: tb/rtc_irq_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: the driver pushes expected observations into a queue; the monitor pops each
// one and compares it with the outputs sampled at the falling edge.
module rtc_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [3:0] ctrl_wdata = 4'h0;
    logic       set_mode = 1'b0;
    logic       rate_tick = 1'b0;
    logic       upd_pulse = 1'b0;
    logic       flag_rd = 1'b0;
    logic [7:0] cur_hr = 8'h00, cur_min = 8'h00, cur_sec = 8'h00;
    logic [7:0] alm_hr = 8'h00, alm_min = 8'h00, alm_sec = 8'h00;
    logic       irq_n;
    logic       sqw;
    logic [3:0] en_out;
    logic [2:0] flags_out;

    // Observation word: {irq_n, sqw, en[3:0], flags[2:0]}
    localparam logic [8:0] M_IRQ = 9'h100;
    localparam logic [8:0] M_SQW = 9'h080;
    localparam logic [8:0] M_EN  = 9'h078;
    localparam logic [8:0] M_FL  = 9'h007;

    typedef struct {
        string      req;
        logic [8:0] mask;
        logic [8:0] exp;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    always #2.5 clk = ~clk;

    rtc_irq_ctrl u_rtc_irq_ctrl (
        .clk (clk), .rst_n (rst_n), .ctrl_we (ctrl_we), .ctrl_wdata (ctrl_wdata),
        .set_mode (set_mode), .rate_tick (rate_tick), .upd_pulse (upd_pulse),
        .flag_rd (flag_rd), .cur_hr (cur_hr), .cur_min (cur_min), .cur_sec (cur_sec),
        .alm_hr (alm_hr), .alm_min (alm_min), .alm_sec (alm_sec), .irq_n (irq_n),
        .sqw (sqw), .en_out (en_out), .flags_out (flags_out)
    );

    // Monitor: pop each expected item and compare it with the live outputs.
    initial begin
        forever begin
            item_t it;
            logic [8:0] obs;
            wait (q.size() > 0);
            it  = q.pop_front();
            obs = {irq_n, sqw, en_out, flags_out};
            n_chk++;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h (mask %h)", it.req, obs & it.mask,
                         it.exp & it.mask, it.mask);
            end
        end
    end

    // Driver helper: queue one expectation and let the monitor consume it.
    task automatic expect_obs(input string req, input logic [8:0] mask, input logic [8:0] exp);
        item_t it;
        it.req = req; it.mask = mask; it.exp = exp;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_en(input logic [3:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        step();
        ctrl_we = 1'b0;
    endtask

    task automatic tick();
        rate_tick = 1'b1;
        step();
        rate_tick = 1'b0;
    endtask

    task automatic update();
        upd_pulse = 1'b1;
        step();
        upd_pulse = 1'b0;
    endtask

    task automatic rd_flags(input string req, input logic [2:0] exp);
        flag_rd = 1'b1;
        expect_obs(req, M_FL, {6'b0, exp});
        step();
        flag_rd = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        step(); step();
        // R1: reset state
        expect_obs("R1 reset", M_IRQ | M_SQW | M_EN | M_FL, {1'b1, 1'b0, 4'h0, 3'h0});
        rst_n = 1'b1;
        step();

        // R2: tick with periodic enable off sets the flag, irq stays high
        tick();
        expect_obs("R2 tick flag", M_IRQ | M_FL, {1'b1, 1'b0, 4'h0, 3'b001});

        // R9 / R3: enable periodic -> irq low
        wr_en(4'b0001);
        expect_obs("R9 write", M_EN, {1'b0, 1'b0, 4'b0001, 3'h0});
        expect_obs("R3 per irq", M_IRQ, 9'h000);

        // R4: read returns flags and clears, irq high
        rd_flags("R4 read value", 3'b001);
        expect_obs("R4 read clears", M_IRQ | M_FL, {1'b1, 8'h00});

        // R5: alarm match with alarm enable off
        cur_hr = 8'h10; cur_min = 8'h20; cur_sec = 8'h30;
        alm_hr = 8'h10; alm_min = 8'h20; alm_sec = 8'h30;
        update();
        expect_obs("R5 alarm+upd flags", M_IRQ | M_FL, {1'b1, 5'h0, 3'b110});

        // R7: held match, no pulse, no new alarm after a read
        rd_flags("R7 read", 3'b110);
        step(); step(); step();
        expect_obs("R7 no repeat", M_FL, 9'h000);

        // R3: alarm enable alone drives irq from the alarm flag
        wr_en(4'b0010);
        update();
        expect_obs("R3 alm irq", M_IRQ | M_FL, {1'b0, 5'h0, 3'b110});
        rd_flags("R4 read alm", 3'b110);
        expect_obs("R4 irq release", M_IRQ, 9'h100);

        // R6: wildcard fields match a differing time
        alm_hr = 8'hC0; alm_min = 8'hC5; cur_sec = 8'h30; alm_sec = 8'h30;
        cur_hr = 8'h23; cur_min = 8'h59;
        update();
        expect_obs("R6 wildcard", M_FL, {6'h0, 3'b110});
        rd_flags("R6 read", 3'b110);

        // R6: one ordinary mismatching field blocks the alarm
        alm_sec = 8'h31;
        update();
        expect_obs("R6 mismatch", M_FL, {6'h0, 3'b100});
        rd_flags("R6 read2", 3'b100);

        // R8: set-mode rise drops update enable, keeps others, wins over a write
        wr_en(4'b0111);
        set_mode = 1'b1; ctrl_we = 1'b1; ctrl_wdata = 4'b0111;
        step();
        ctrl_we = 1'b0;
        expect_obs("R8 set rise", M_EN, {2'b0, 4'b0011, 3'h0});
        wr_en(4'b0111);
        expect_obs("R8 level no clear", M_EN, {2'b0, 4'b0111, 3'h0});
        set_mode = 1'b0;
        wr_en(4'b0000);

        // R11: event colliding with a read keeps its flag
        tick();
        rate_tick = 1'b1; flag_rd = 1'b1;
        step();
        rate_tick = 1'b0; flag_rd = 1'b0;
        expect_obs("R11 collide", M_FL, {6'h0, 3'b001});
        rd_flags("R11 read", 3'b001);

        // R10: square wave toggles on ticks, then falls when disabled
        wr_en(4'b1000);
        expect_obs("R10 idle low", M_SQW, 9'h000);
        tick();
        expect_obs("R10 toggle high", M_SQW, 9'h080);
        tick();
        expect_obs("R10 toggle low", M_SQW, 9'h000);
        tick();
        wr_en(4'b0000);
        expect_obs("R10 held before clear", M_SQW, 9'h080);
        step();
        expect_obs("R10 disabled low", M_SQW, 9'h000);
        tick();
        expect_obs("R10 tick ignored", M_SQW, 9'h000);

        // R1: reset mid-run clears enables and flags
        wr_en(4'b1111);
        tick();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        expect_obs("R1 rerun reset", M_IRQ | M_SQW | M_EN | M_FL, {1'b1, 1'b0, 4'h0, 3'h0});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule